// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a register-mapped watchdog built around a 64-bit up-counter and a 64-bit period. Software sets up the counter, the period, a count mode and a global control word while the block is idle. It then arms the block with two 16-bit keys written one after the other into the upper half of the guard register. Once the block is armed, all configuration is frozen. Only the key field of the guard register still has any effect.

While the block is running, software must keep feeding it the same two-key pair. Each complete pair clears the counter. If the counter reaches the period, or if any key other than the expected one is written, the block sets a sticky timeout flag and sends a one-cycle reset request to the system reset controller. After that it stays tripped until a system reset.

Top module: `kwd_top`

## Requirements
- R1: While idle, every configuration register reads back what was last written to it. The offsets are: counter low 0x10, counter high 0x14, period low 0x18, period high 0x1C, count control 0x20 (mode in bits 7:6), global control 0x24 (release bits 1:0, mode field 3:2) and guard 0x28. Reads of any other bit return 0.
- R2: Arming takes two writes to 0x28. The first carries key 0xA5C6 in bits 31:16 with bit 14 set, while the global mode field equals 2. The second carries key 0xDA7E with bit 14 set. Once the block is armed, bit 14 of 0x28 reads 1.
- R3: Once the first arming key has been accepted, writes to offsets 0x10 through 0x24 have no effect.
- R4: While running, key 0xA5C6 followed by key 0xDA7E clears the 64-bit counter to zero on the second write, and no reset request is raised.
- R5: While armed, any write to 0x28 whose key is not the expected one raises the reset request on the next cycle and sets the flag (bit 15 of 0x28).
- R6: While running, the block trips on a cycle in which the counter would count and already equals the period. After the trip the counter holds its value.
- R7: The reset request lasts exactly one cycle. The flag stays set until a system reset, whatever is written to bit 15. Once tripped, the block ignores all further keys.
- R8: The counter advances only when the count mode in bits 7:6 is nonzero and both release bits (bits 0 and 1 of 0x24) are 1.
- R9: While the block is not running, count mode 1 (one-shot) holds the counter at the period. Count mode 2 (continuous) returns the counter to 0 after it reaches the period.
- R10: With a period of zero, the block trips on the first counted cycle after it starts running.
- R11: While idle, a wrong key, or the first key written without bit 14 set, leaves the block idle and raises no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The checker watches every cycle for the following:
- the reset request never lasts more than one cycle;
- the flag never falls and never rises without a request;
- the period stays frozen while the block is armed;
- the counter is zero after a completed service pair;
- the counter stays put once the block has tripped;
- the idle state leads only to the idle or pre-armed state.

Some behaviours depend on whole register sequences, so only the bench scenarios can show them. These are the exact trip cycle for a period of zero, the one-shot hold and continuous wrap, gating by the release bits, mode-field gating of arming, and keys being ignored after a trip.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   typedef enum logic [2:0] {
      ST_OFF  = 3'd0,
      ST_PRE  = 3'd1,
      ST_RUN  = 3'd2,
      ST_SVC  = 3'd3,
      ST_TRIP = 3'd4
   } wd_state_e;

   localparam int OFS_CNT_LO = 'h10;
   localparam int OFS_CNT_HI = 'h14;
   localparam int OFS_PER_LO = 'h18;
   localparam int OFS_PER_HI = 'h1C;
   localparam int OFS_TCTL   = 'h20;
   localparam int OFS_GCTL   = 'h24;
   localparam int OFS_GUARD  = 'h28;

   localparam logic [1:0] GMODE_WATCH = 2'd2;
   localparam logic [1:0] TMODE_ONCE  = 2'd1;
endpackage

// File: rtl/kwd_cfg.sv
module kwd_cfg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unlocked,
   input  logic              wr_per_lo,
   input  logic              wr_per_hi,
   input  logic              wr_tctl,
   input  logic              wr_gctl,
   input  logic [DATA_W-1:0] wdata,
   output logic [2*DATA_W-1:0] per,
   output logic [1:0]        tmode,
   output logic [1:0]        gmode,
   output logic [1:0]        release_bits
);
   logic [1:0] wr_half;
   assign wr_half = {wr_per_hi, wr_per_lo};

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [DATA_W-1:0] half_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     half_q <= '0;
         else if (unlocked && wr_half[h]) half_q <= wdata;
      end
      assign per[h*DATA_W +: DATA_W] = half_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmode        <= '0;
         gmode        <= '0;
         release_bits <= '0;
      end else if (unlocked) begin
         if (wr_tctl) tmode <= wdata[7:6];
         if (wr_gctl) begin
            gmode        <= wdata[3:2];
            release_bits <= wdata[1:0];
         end
      end
   end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_lo,
   input  logic                load_hi,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                tick_en,
   input  logic                clear,
   input  logic                hold,
   input  logic                watching,
   input  logic                oneshot,
   input  logic [2*DATA_W-1:0] per,
   output logic [2*DATA_W-1:0] cnt,
   output logic                at_per
);
   localparam int CNT_W = 2 * DATA_W;

   assign at_per = (cnt == per);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clear)       cnt <= '0;
      else if (load_lo)     cnt[DATA_W-1:0] <= wdata;
      else if (load_hi)     cnt[CNT_W-1:DATA_W] <= wdata;
      else if (hold)        cnt <= cnt;
      else if (tick_en) begin
         if (!watching && at_per) cnt <= oneshot ? cnt : '0;
         else                     cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/kwd_keyfsm.sv
module kwd_keyfsm #(
   parameter logic [15:0] KEY_A = 16'hA5C6,
   parameter logic [15:0] KEY_B = 16'hDA7E
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               key_wr,
   input  logic [15:0]        key,
   input  logic               en_bit,
   input  logic               mode_ok,
   input  logic               expire,
   output kwd_pkg::wd_state_e state,
   output logic               trip_now,
   output logic               svc_clear,
   output logic               req_q,
   output logic               flag_q
);
   import kwd_pkg::*;
   wd_state_e nxt;

   always_comb begin
      nxt       = state;
      trip_now  = 1'b0;
      svc_clear = 1'b0;
      unique case (state)
         ST_OFF: if (key_wr && key == KEY_A && en_bit && mode_ok) nxt = ST_PRE;
         ST_PRE: if (key_wr) begin
            if (key == KEY_B && en_bit) nxt = ST_RUN;
            else                        trip_now = 1'b1;
         end
         ST_RUN: if (expire) trip_now = 1'b1;
            else if (key_wr) begin
               if (key == KEY_A) nxt = ST_SVC;
               else              trip_now = 1'b1;
            end
         ST_SVC: if (expire) trip_now = 1'b1;
            else if (key_wr) begin
               if (key == KEY_B) begin
                  nxt       = ST_RUN;
                  svc_clear = 1'b1;
               end else trip_now = 1'b1;
            end
         default: ;
      endcase
      if (trip_now) nxt = ST_TRIP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_OFF;
         req_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         state  <= nxt;
         req_q  <= trip_now;
         flag_q <= flag_q | trip_now;
      end
   end
endmodule

// File: rtl/kwd_top.sv
module kwd_top #(
   parameter int          ADDR_W = 8,
   parameter int          DATA_W = 32,
   parameter logic [15:0] KEY_A  = 16'hA5C6,
   parameter logic [15:0] KEY_B  = 16'hDA7E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rst_req
);
   import kwd_pkg::*;
   localparam int CNT_W = 2 * DATA_W;

   if (DATA_W != 32) begin : g_bad_width
      $error("kwd_top: DATA_W must be 32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("kwd_top: ADDR_W too small for the register offsets");
   end
   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("kwd_top: the two keys must differ");
   end

   localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFS_CNT_LO);
   localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFS_CNT_HI);
   localparam logic [ADDR_W-1:0] A_PER_LO = ADDR_W'(OFS_PER_LO);
   localparam logic [ADDR_W-1:0] A_PER_HI = ADDR_W'(OFS_PER_HI);
   localparam logic [ADDR_W-1:0] A_TCTL   = ADDR_W'(OFS_TCTL);
   localparam logic [ADDR_W-1:0] A_GCTL   = ADDR_W'(OFS_GCTL);
   localparam logic [ADDR_W-1:0] A_GUARD  = ADDR_W'(OFS_GUARD);

   wd_state_e        state_q;
   logic             unlocked, watching, tick_en, hold;
   logic             trip_now, svc_clear, flag_q, at_per, expire;
   logic [CNT_W-1:0] per_q, cnt_q;
   logic [1:0]       tmode, gmode, rel;

   assign unlocked = (state_q == ST_OFF);
   assign watching = (state_q == ST_RUN) || (state_q == ST_SVC);
   assign tick_en  = (tmode != 2'd0) && (&rel);
   assign expire   = tick_en && at_per;
   assign hold     = trip_now || (state_q == ST_TRIP);

   kwd_cfg #(.DATA_W(DATA_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .unlocked(unlocked),
      .wr_per_lo(bus_we && bus_addr == A_PER_LO),
      .wr_per_hi(bus_we && bus_addr == A_PER_HI),
      .wr_tctl(bus_we && bus_addr == A_TCTL),
      .wr_gctl(bus_we && bus_addr == A_GCTL),
      .wdata(bus_wdata), .per(per_q), .tmode(tmode),
      .gmode(gmode), .release_bits(rel)
   );

   kwd_counter #(.DATA_W(DATA_W)) cnt_i (
      .clk(clk), .rst_n(rst_n),
      .load_lo(unlocked && bus_we && bus_addr == A_CNT_LO),
      .load_hi(unlocked && bus_we && bus_addr == A_CNT_HI),
      .wdata(bus_wdata), .tick_en(tick_en), .clear(svc_clear),
      .hold(hold), .watching(watching), .oneshot(tmode == TMODE_ONCE),
      .per(per_q), .cnt(cnt_q), .at_per(at_per)
   );

   kwd_keyfsm #(.KEY_A(KEY_A), .KEY_B(KEY_B)) fsm_i (
      .clk(clk), .rst_n(rst_n),
      .key_wr(bus_we && bus_addr == A_GUARD),
      .key(bus_wdata[DATA_W-1 -: 16]), .en_bit(bus_wdata[14]),
      .mode_ok(gmode == GMODE_WATCH), .expire(expire && watching),
      .state(state_q), .trip_now(trip_now), .svc_clear(svc_clear),
      .req_q(rst_req), .flag_q(flag_q)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
         A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
         A_PER_LO: bus_rdata = per_q[DATA_W-1:0];
         A_PER_HI: bus_rdata = per_q[CNT_W-1:DATA_W];
         A_TCTL:   bus_rdata[7:6] = tmode;
         A_GCTL:   bus_rdata[3:0] = {gmode, rel};
         A_GUARD:  begin
            bus_rdata[15] = flag_q;
            bus_rdata[14] = !unlocked;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
   parameter int          ADDR_W = 8,
   parameter int          DATA_W = 32,
   parameter logic [15:0] KEY_B  = 16'hDA7E
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                rst_req,
   input kwd_pkg::wd_state_e  state,
   input logic                flag,
   input logic [2*DATA_W-1:0] cnt,
   input logic [2*DATA_W-1:0] per
);
   import kwd_pkg::*;
   localparam logic [ADDR_W-1:0] A_GUARD = ADDR_W'(OFS_GUARD);

   assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag |=> flag);
   assert_flag_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> rst_req);
   assert_period_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_OFF) |=> $stable(per));
   assert_service_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SVC && bus_we && bus_addr == A_GUARD
       && bus_wdata[DATA_W-1 -: 16] == KEY_B && !rst_req && !flag)
      |=> (cnt == '0 || state == ST_TRIP));
   assert_trip_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TRIP) |=> $stable(cnt));
   assert_arm_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF) |=> (state == ST_OFF || state == ST_PRE));
endmodule

bind kwd_top kwd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_B(KEY_B)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .rst_req(rst_req), .state(state_q),
   .flag(flag_q), .cnt(cnt_q), .per(per_q)
);

// File: tb/kwd_top_tb.sv
module kwd_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rst_req;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   kwd_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
   );

   always @(negedge clk) if (rst_req) pulses++;

   localparam logic [31:0] ARM_A = 32'hA5C6_4000;
   localparam logic [31:0] ARM_B = 32'hDA7E_4000;
   localparam logic [31:0] SRV_A = 32'hA5C6_0000;
   localparam logic [31:0] SRV_B = 32'hDA7E_0000;

   // op: 1 = write, 2 = read and compare
   typedef struct packed { logic [1:0] op; logic [7:0] addr; logic [31:0] data; } vec_t;
   localparam vec_t VECS [14] = '{
      '{2'd1, 8'h18, 32'h0000_03E8}, '{2'd1, 8'h1C, 32'h0000_0001},
      '{2'd1, 8'h24, 32'h0000_000B}, '{2'd1, 8'h10, 32'h0000_0055},
      '{2'd1, 8'h14, 32'h0000_0002}, '{2'd1, 8'h20, 32'h0000_003F},
      '{2'd2, 8'h18, 32'h0000_03E8}, '{2'd2, 8'h1C, 32'h0000_0001},
      '{2'd2, 8'h24, 32'h0000_000B}, '{2'd2, 8'h10, 32'h0000_0055},
      '{2'd2, 8'h14, 32'h0000_0002}, '{2'd2, 8'h20, 32'h0000_0000},
      '{2'd2, 8'h28, 32'h0000_0000}, '{2'd2, 8'h30, 32'h0000_0000}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      pulses = 0;
   endtask

   task automatic setup(input logic [31:0] per, input logic [31:0] tctl);
      wr(8'h24, 32'hB);
      wr(8'h18, per);
      wr(8'h1C, 32'h0);
      wr(8'h10, 32'h0);
      wr(8'h20, tctl);
   endtask

   initial begin
      logic [31:0] v, v2;
      do_reset();

      rd(8'h28, v);  check("R7 reset flag", v, 32'h0);
      check("R7 reset req", rst_req, 1'b0);
      rd(8'h10, v);  check("R1 reset counter", v, 32'h0);

      foreach (VECS[i]) begin
         if (VECS[i].op == 2'd1) wr(VECS[i].addr, VECS[i].data);
         else begin
            rd(VECS[i].addr, v);
            check("R1 readback", v, VECS[i].data);
         end
      end

      // R8: release bits clear, counter frozen
      do_reset();
      wr(8'h24, 32'h8); wr(8'h18, 32'd100); wr(8'h20, 32'h80);
      repeat (5) @(negedge clk);
      rd(8'h10, v); check("R8 no release no count", v, 32'h0);
      wr(8'h24, 32'hB);
      repeat (5) @(negedge clk);
      rd(8'h10, v); check("R8 counting with release", v != 0, 1'b1);

      // R9 one-shot holds at period
      do_reset();
      setup(32'd4, 32'h40);
      repeat (10) @(negedge clk);
      rd(8'h10, v); check("R9 one-shot hold", v, 32'd4);
      // R9 continuous wraps
      do_reset();
      setup(32'd4, 32'h80);
      v2 = 0;
      for (int k = 0; k < 12; k++) begin
         rd(8'h10, v);
         if (v > 4) v2 = 32'hBAD;
         @(negedge clk);
      end
      check("R9 continuous stays within period", v2, 32'h0);

      // R11 idle ignores wrong keys; R2 needs watchdog mode
      do_reset();
      setup(32'd1000, 32'h80);
      wr(8'h28, 32'h1234_4000);
      wr(8'h28, SRV_A);
      rd(8'h28, v); check("R11 still idle", v, 32'h0);
      check("R11 no request", pulses, 0);
      wr(8'h24, 32'h3);
      wr(8'h28, ARM_A);
      rd(8'h28, v); check("R2 mode field gates arming", v, 32'h0);

      // R2 arm, R3 lock, R4 service
      do_reset();
      setup(32'd1000, 32'h80);
      wr(8'h28, ARM_A);
      wr(8'h18, 32'd7);
      rd(8'h18, v); check("R3 period locked after first key", v, 32'd1000);
      wr(8'h28, ARM_B);
      rd(8'h28, v); check("R2 armed bit", v, 32'h4000);
      wr(8'h10, 32'h0);
      wr(8'h24, 32'h0);
      rd(8'h24, v); check("R3 global control locked", v, 32'hB);
      repeat (20) @(negedge clk);
      wr(8'h28, SRV_A);
      wr(8'h28, SRV_B);
      rd(8'h10, v); check("R4 service clears counter", v, 32'h0);
      check("R4 no request on service", pulses, 0);

      // R5 wrong key while running; R7 pulse and sticky flag
      wr(8'h28, 32'h1234_4000);
      check("R5 request after bad key", rst_req, 1'b1);
      rd(8'h28, v); check("R5 flag set", v[15], 1'b1);
      @(negedge clk);
      check("R7 request one cycle", rst_req, 1'b0);
      wr(8'h28, 32'h0000_8000);
      wr(8'h28, 32'h0000_0000);
      rd(8'h28, v); check("R7 flag sticky", v[15], 1'b1);
      wr(8'h28, SRV_A); wr(8'h28, SRV_B); wr(8'h28, 32'h5555_0000);
      check("R7 keys ignored after trip", pulses, 1);

      // R5 wrong key in pre-armed state
      do_reset();
      setup(32'd1000, 32'h80);
      wr(8'h28, ARM_A);
      wr(8'h28, ARM_A);
      check("R5 bad second key", rst_req, 1'b1);

      // R6 counter reaches period
      do_reset();
      setup(32'd20, 32'h80);
      wr(8'h28, ARM_A); wr(8'h28, ARM_B);
      repeat (40) @(negedge clk);
      check("R6 one trip", pulses, 1);
      rd(8'h10, v); check("R6 counter held at period", v, 32'd20);
      repeat (3) @(negedge clk);
      rd(8'h10, v2); check("R6 counter stays", v2, 32'd20);

      // R10 period zero
      do_reset();
      setup(32'd0, 32'h80);
      wr(8'h28, ARM_A); wr(8'h28, ARM_B);
      check("R10 no request yet", rst_req, 1'b0);
      @(negedge clk);
      check("R10 request on first counted cycle", rst_req, 1'b1);
      rd(8'h28, v); check("R10 flag", v[15], 1'b1);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule